// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Clock Generator

This block derives the switch-control phases of a switched-capacitor second-order sigma-delta modulator from a fast reference clock. One modulator period is cut into a fixed number of fast-clock ticks. A free-running tick counter walks through the period. A registered decoder turns each counter value into two main phases, a sampling phase and a longer integration phase. The two main phases are never high together, and a guard tick separates them.

Each main phase has an auxiliary companion. The companion rises with its main phase and is held one tick longer, so that it uses up the guard tick that follows. The block also emits a one-tick strobe at the start of every period for downstream decimation or test logic. A low enable parks every phase low and freezes the counter. When enable returns, the sequence resumes from the frozen position.

Top module: `nonoverlap_phase_gen`

## Requirements
- R1: The sampling phase `samp_o` and the integration phase `integ_o` are never high in the same tick.
- R2: With the default parameters, a period is 40 ticks. Ticks are numbered 0..39 from the period start. `samp_o` is high for exactly 11 consecutive ticks, numbered 0..10.
- R3: `integ_o` is high for exactly 27 consecutive ticks, numbered 12..38. It rises only after `samp_o` has been low for one guard tick (tick 11).
- R4: After `integ_o` falls there is one guard tick (tick 39) with both main phases low. The next period's sampling phase then starts, so a period is 40 ticks.
- R5: `samp_aux_o` rises together with `samp_o` and falls one tick after it. It is therefore high for 12 ticks, numbered 0..11.
- R6: `integ_aux_o` rises together with `integ_o` and falls one tick after it. It is therefore high for 28 ticks, numbered 12..39.
- R7: The two auxiliary phases are never high together. `samp_aux_o` is never high with `integ_o`, and `integ_aux_o` is never high with `samp_o`.
- R8: `period_start_o` is high for exactly one tick per period, the tick numbered 0, and only while `samp_o` is high.
- R9: While `rst_n` is low at a clock edge, all five outputs are low after that edge and the position is cleared to 0. The first enabled tick after reset is tick 0, with the sampling phase and the strobe high.
- R10: An edge with `en` low drives all five outputs low and holds the position. The next enabled edge produces the tick that would have followed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock, one tick per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Advance enable; low parks all phases low |
| samp_o | output | 1 | Sampling phase |
| integ_o | output | 1 | Integration phase |
| samp_aux_o | output | 1 | Widened companion of the sampling phase |
| integ_aux_o | output | 1 | Widened companion of the integration phase |
| period_start_o | output | 1 | One-tick strobe at the first tick of each period |

## Verification
The hardest situation to reach is a pause that lands on one of the four edges inside a period. The position is frozen there, and on resume an auxiliary phase may rise on its own while its main phase stays low. The stimulus moves a two-tick enable gap along the period in one-tick steps, which places a pause at every one of the 40 positions. A mid-run reset is also issued so that the restart at tick 0 is seen from a partly advanced state.

// File: rtl/phase_gen_pkg.sv
// Package phase_gen_pkg
// Shared types for the non-overlapping phase generator.
// Assumes: all five outputs travel together as one packed bundle.
package phase_gen_pkg;

    // One registered snapshot of every generated phase.
    typedef struct packed {
        logic samp;
        logic samp_aux;
        logic integ;
        logic integ_aux;
        logic strobe;
    } phase_set_t;

    // Index names for the two main-phase windows built in the decoder.
    localparam int unsigned WIN_SAMP  = 0;
    localparam int unsigned WIN_INTEG = 1;
    localparam int unsigned WIN_COUNT = 2;

endpackage

// File: rtl/phase_tick_counter.sv
// Module phase_tick_counter
// Walks a position counter through 0..PERIOD_TICKS-1 and wraps back to 0.
// Assumes: synchronous active-low reset; a low enable holds the position.
module phase_tick_counter #(
    parameter int unsigned PERIOD_TICKS = 40,
    localparam int unsigned CW = $clog2(PERIOD_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic [CW-1:0] pos
);

    localparam logic [CW-1:0] LAST = CW'(PERIOD_TICKS - 1);

    // Advance the position on enabled ticks, wrapping at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (en) begin
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
        end
    end

endmodule

// File: rtl/phase_window_decode.sv
// Module phase_window_decode
// Turns a period position into the combinational phase set.
// Assumes: the period is laid out as sample, gap, integrate, gap; the
// layout exactly fills PERIOD_TICKS; each auxiliary window is its main
// window widened by the following gap.
module phase_window_decode
    import phase_gen_pkg::*;
#(
    parameter int unsigned PERIOD_TICKS = 40,
    parameter int unsigned SAMP_TICKS   = 11,
    parameter int unsigned INTEG_TICKS  = 27,
    parameter int unsigned GAP_TICKS    = 1,
    localparam int unsigned CW = $clog2(PERIOD_TICKS)
) (
    input  logic [CW-1:0] pos,
    output phase_set_t    nxt
);

    localparam int unsigned INTEG_BEG = SAMP_TICKS + GAP_TICKS;

    logic [WIN_COUNT-1:0] main_hit;
    logic [WIN_COUNT-1:0] aux_hit;

    // One main window and one widened auxiliary window per phase.
    for (genvar w = 0; w < WIN_COUNT; w++) begin : g_win
        localparam int unsigned BEG = (w == WIN_SAMP) ? 0 : INTEG_BEG;
        localparam int unsigned LEN = (w == WIN_SAMP) ? SAMP_TICKS : INTEG_TICKS;
        localparam int unsigned END_MAIN = BEG + LEN;
        localparam int unsigned END_AUX  = END_MAIN + GAP_TICKS;

        // Range compare of the position against this window's bounds.
        always_comb begin
            main_hit[w] = (32'(pos) >= BEG) && (32'(pos) < END_MAIN);
            aux_hit[w]  = (32'(pos) >= BEG) && (32'(pos) < END_AUX);
        end
    end

    // Gather the window hits and the period-start flag into one bundle.
    always_comb begin
        nxt.samp      = main_hit[WIN_SAMP];
        nxt.samp_aux  = aux_hit[WIN_SAMP];
        nxt.integ     = main_hit[WIN_INTEG];
        nxt.integ_aux = aux_hit[WIN_INTEG];
        nxt.strobe    = (pos == '0);
    end

endmodule

// File: rtl/phase_out_reg.sv
// Module phase_out_reg
// Registers the decoded phase set so every output leaves a flop.
// Assumes: synchronous active-low reset; a low enable clears the bundle.
module phase_out_reg
    import phase_gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  phase_set_t nxt,
    output phase_set_t q
);

    // Capture the decode on enabled ticks, park low otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/nonoverlap_phase_gen.sv
// Module nonoverlap_phase_gen
// Produces asymmetric non-overlapping sampling/integration phases, their
// widened companions and a period-start strobe from a fast clock.
// Assumes: SAMP_TICKS + INTEG_TICKS + 2*GAP_TICKS == PERIOD_TICKS.
module nonoverlap_phase_gen
    import phase_gen_pkg::*;
#(
    parameter int unsigned PERIOD_TICKS = 40,
    parameter int unsigned SAMP_TICKS   = 11,
    parameter int unsigned INTEG_TICKS  = 27,
    parameter int unsigned GAP_TICKS    = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic samp_o,
    output logic integ_o,
    output logic samp_aux_o,
    output logic integ_aux_o,
    output logic period_start_o
);

    localparam int unsigned CW = $clog2(PERIOD_TICKS);

    logic [CW-1:0] pos;
    phase_set_t    nxt;
    phase_set_t    q;

    phase_tick_counter #(
        .PERIOD_TICKS (PERIOD_TICKS)
    ) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .pos   (pos)
    );

    phase_window_decode #(
        .PERIOD_TICKS (PERIOD_TICKS),
        .SAMP_TICKS   (SAMP_TICKS),
        .INTEG_TICKS  (INTEG_TICKS),
        .GAP_TICKS    (GAP_TICKS)
    ) i_dec (
        .pos (pos),
        .nxt (nxt)
    );

    phase_out_reg i_oreg (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .nxt   (nxt),
        .q     (q)
    );

    // Unpack the registered bundle onto the ports.
    always_comb begin
        samp_o         = q.samp;
        samp_aux_o     = q.samp_aux;
        integ_o        = q.integ;
        integ_aux_o    = q.integ_aux;
        period_start_o = q.strobe;
    end

endmodule

// File: rtl/phase_gen_checker.sv
// Module phase_gen_checker
// Port-level temporal properties of nonoverlap_phase_gen.
// Assumes: attached through the bind below; reset is synchronous active-low.
module phase_gen_checker (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic samp_o,
    input logic integ_o,
    input logic samp_aux_o,
    input logic integ_aux_o,
    input logic period_start_o
);

    p_main_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(samp_o && integ_o));

    p_integ_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(integ_o) |-> !$past(samp_o));

    p_samp_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(samp_o) |-> !$past(integ_o));

    p_samp_aux_cover_r5: assert property (@(posedge clk) disable iff (!rst_n)
        samp_o |-> samp_aux_o);

    p_samp_aux_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(samp_o) && $past(en)) |-> samp_aux_o);

    p_integ_aux_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
        integ_o |-> integ_aux_o);

    p_integ_aux_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(integ_o) && $past(en)) |-> integ_aux_o);

    p_aux_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(samp_aux_o && integ_aux_o) && !(samp_aux_o && integ_o)
        && !(integ_aux_o && samp_o));

    p_strobe_in_samp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        period_start_o |-> samp_o);

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        period_start_o |=> !period_start_o);

    p_reset_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !(samp_o || integ_o || samp_aux_o || integ_aux_o || period_start_o));

    p_pause_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(en) && $past(rst_n)) |->
        !(samp_o || integ_o || samp_aux_o || integ_aux_o || period_start_o));

endmodule

bind nonoverlap_phase_gen phase_gen_checker i_phase_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .en             (en),
    .samp_o         (samp_o),
    .integ_o        (integ_o),
    .samp_aux_o     (samp_aux_o),
    .integ_aux_o    (integ_aux_o),
    .period_start_o (period_start_o)
);

// File: tb/test_nonoverlap_phase_gen.sv
module test_nonoverlap_phase_gen;

    localparam int P  = 40;
    localparam int S  = 11;
    localparam int I  = 27;
    localparam int G  = 1;
    localparam int IB = S + G;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic samp_o, integ_o, samp_aux_o, integ_aux_o, period_start_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit steady = 1'b0;

    // Bench model state, advanced on the same edge as the design.
    int  m_idx = 0;
    bit  m_rst = 1'b1;
    bit  m_pause = 1'b0;
    logic [4:0] m_exp = '0; // samp, samp_aux, integ, integ_aux, strobe

    always #5 clk = ~clk;

    nonoverlap_phase_gen i_nonoverlap_phase_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .en             (en),
        .samp_o         (samp_o),
        .integ_o        (integ_o),
        .samp_aux_o     (samp_aux_o),
        .integ_aux_o    (integ_aux_o),
        .period_start_o (period_start_o)
    );

    function automatic logic [4:0] expect_at(int k);
        logic [4:0] e;
        e[4] = (k < S);
        e[3] = (k < S + G);
        e[2] = (k >= IB) && (k < IB + I);
        e[1] = (k >= IB);
        e[0] = (k == 0);
        return e;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_exp <= '0; m_idx <= 0; m_rst <= 1'b1; m_pause <= 1'b0;
        end else if (en) begin
            m_exp <= expect_at(m_idx);
            m_idx <= (m_idx + 1) % P;
            m_rst <= 1'b0; m_pause <= 1'b0;
        end else begin
            m_exp <= '0; m_rst <= 1'b0; m_pause <= 1'b1;
        end
    end

    task automatic check(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the model at each falling edge.
    int run_s = 0, run_i = 0, run_sa = 0, run_ia = 0, since_strobe = 0;
    logic p_s = 0, p_i = 0, p_sa = 0, p_ia = 0;
    always @(negedge clk) begin
        if (m_rst) begin
            check("R9 samp", samp_o, 1'b0);
            check("R9 integ", integ_o, 1'b0);
            check("R9 aux", samp_aux_o | integ_aux_o, 1'b0);
            check("R9 strobe", period_start_o, 1'b0);
        end else if (m_pause) begin
            check("R10 all-low", samp_o | integ_o | samp_aux_o | integ_aux_o | period_start_o, 1'b0);
        end else begin
            check("R2 samp", samp_o, m_exp[4]);
            check("R5 samp_aux", samp_aux_o, m_exp[3]);
            check("R3 integ", integ_o, m_exp[2]);
            check("R6 integ_aux", integ_aux_o, m_exp[1]);
            check("R8 strobe", period_start_o, m_exp[0]);
        end
        check("R1 exclusive", samp_o & integ_o, 1'b0);
        check("R7 aux exclusive", (samp_aux_o & integ_aux_o) | (samp_aux_o & integ_o) | (integ_aux_o & samp_o), 1'b0);
        // Run-length measurement while enable is held high.
        if (steady) begin
            if (p_s && !samp_o) check("R2 samp length", run_s == S, 1'b1);
            if (p_i && !integ_o) check("R3 integ length", run_i == I, 1'b1);
            if (p_sa && !samp_aux_o) check("R5 samp_aux length", run_sa == S + G, 1'b1);
            if (p_ia && !integ_aux_o) check("R6 integ_aux length", run_ia == I + G, 1'b1);
            if (period_start_o && since_strobe != 0) check("R4 period length", since_strobe == P, 1'b1);
        end
        run_s  = samp_o ? run_s + 1 : 0;
        run_i  = integ_o ? run_i + 1 : 0;
        run_sa = samp_aux_o ? run_sa + 1 : 0;
        run_ia = integ_aux_o ? run_ia + 1 : 0;
        since_strobe = period_start_o ? 1 : (since_strobe == 0 ? 0 : since_strobe + 1);
        p_s = samp_o; p_i = integ_o; p_sa = samp_aux_o; p_ia = integ_aux_o;
    end

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b0;
        ticks(3);
        // R9: release reset with enable high; first tick must be tick 0.
        rst_n = 1'b1; en = 1'b1; steady = 1'b1;
        @(negedge clk);
        check("R9 first samp", samp_o, 1'b1);
        check("R9 first strobe", period_start_o, 1'b1);
        ticks(6 * P);
        steady = 1'b0;
        // R10: slide a two-tick pause across every period position.
        for (int k = 0; k < P; k++) begin
            ticks(P + 1);
            en = 1'b0;
            ticks(2);
            en = 1'b1;
        end
        ticks(P / 2);
        // R9: mid-run reset, then restart from tick 0.
        rst_n = 1'b0;
        ticks(2);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 restart samp", samp_o, 1'b1);
        check("R9 restart strobe", period_start_o, 1'b1);
        ticks(2 * P);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule